// File: doc/BRIEF.md
# Decision-LLR insertion sorter

During the first decoding trial of a flip-based successive-cancellation decoder, the leaf decoders emit reliability magnitudes (decision LLRs) for information bits. This block collects those magnitudes together with the matching information-bit index. It keeps only the smallest ones in a list sorted in ascending order. Several pairs may arrive in one cycle. They are placed by a chain of parallel compare-and-shift stages, so the list is already sorted when the first trial ends.

On later trials, the decoder asks for the next bit to flip. Each request returns the index of the next-least-reliable entry, one rank further down the list per request. Trial t (t ≥ 2) therefore receives the index ranked (t-1)-th smallest. When the requests have used up every stored entry, the block answers with an exhausted flag.

Control is a three-state machine:
- COLLECT accepts insertions.
- SERVE hands out indices.
- SPENT answers every request with exhausted.

The transitions are:
- CLEAR (any state → COLLECT, on `clr`).
- CLOSE (COLLECT → SERVE, on `done`).
- LAST_HIT (SERVE → SPENT, when a request takes the final stored entry).
- EMPTY_REQ (SERVE → SPENT, when a request finds nothing stored).

Top module: `llr_flip_sorter`

## Requirements
- R1: After reset the stored count is 0, the state is COLLECT, and neither `rsp_hit` nor `rsp_exh` is asserted.
- R2: Entries are kept in ascending order of their unsigned QW-bit LLR magnitude. Each entry carries an IW = ceil(log2 KBITS)-bit index. Successive requests return the indices in that order.
- R3: The list holds at most D = TMAX-1 entries and retains the D smallest values. A value arriving at a full list that is not smaller than every stored value is discarded, and the count stays at D.
- R4: Up to LANES = min(P-1, TMAX-1) pairs are inserted per cycle, one per asserted bit of `ins_vld`. Lane j occupies bits [j*QW +: QW] of `ins_llr` and bits [j*IW +: IW] of `ins_idx`. Within a cycle, lane 0 counts as arriving first. The count grows by at most LANES per cycle.
- R5: A new value is placed behind every stored value equal to it, so equal LLRs keep their arrival order.
- R6: `clr` empties the list, restarts the request pointer and returns to COLLECT on the next edge. It overrides `done`, `req` and any insertion in the same cycle.
- R7: Insertions are accepted only in COLLECT, including the cycle in which `done` is asserted. In SERVE and SPENT they leave the list and the count unchanged.
- R8: In SERVE, a request yields `rsp_hit` for one cycle on the following edge, with `rsp_idx` holding the index at the current rank. The rank then advances by one.
- R9: A request made once all `fill_cnt` entries have been handed out, or made with an empty list, yields `rsp_exh` for one cycle instead. `rsp_hit` and `rsp_exh` are never high together.
- R10: A request in COLLECT produces no response and does not advance the rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Start of a new codeword: empty the list |
| ins_vld | input | LANES | Per-lane insert strobe |
| ins_llr | input | LANES*QW | Per-lane decision-LLR magnitude |
| ins_idx | input | LANES*IW | Per-lane information-bit index |
| done | input | 1 | First trial finished: stop collecting |
| req | input | 1 | Ask for the next bit to flip |
| fill_cnt | output | CW | Number of stored entries |
| rsp_hit | output | 1 | Response carries a valid index |
| rsp_exh | output | 1 | Response: no entry left |
| rsp_idx | output | IW | Index of the bit to flip |

## Verification
Some behaviours are checked by the assertions on every cycle:
- stored LLRs stay in ascending order across the filled prefix;
- the count never passes D, and grows by at most LANES per edge;
- the count is frozen outside COLLECT;
- a clear empties the list;
- responses appear only after a request, never during collection, and never as hit and exhausted together.

Other behaviours can only be shown by the bench's scenarios, because they depend on which values were offered:
- which values survive an overflow;
- that ties keep their arrival order across lanes and cycles;
- that the returned indices follow the rank order.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_SERVE   = 2'd1,
        ST_SPENT   = 2'd2
    } flip_state_e;

    // Number of insert lanes: bounded by the memory port width and the list depth.
    function automatic int lanes_for(input int port_width, input int tmax);
        int a;
        int b;
        a = port_width - 1;
        b = tmax - 1;
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/llr_insert_stage.sv
module llr_insert_stage #(
    parameter int D  = 7,
    parameter int QW = 6,
    parameter int IW = 7,
    parameter int CW = 3
) (
    input  logic [D-1:0][QW-1:0] llr_i,
    input  logic [D-1:0][IW-1:0] idx_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic                 new_vld,
    input  logic [QW-1:0]        new_llr,
    input  logic [IW-1:0]        new_idx,
    output logic [D-1:0][QW-1:0] llr_o,
    output logic [D-1:0][IW-1:0] idx_o,
    output logic [CW-1:0]        cnt_o
);

    // keep_here[i]: slot i is filled and not larger than the newcomer.
    // On a sorted list this is a run of ones from slot 0.
    logic [D-1:0] keep_here;

    generate
        for (genvar i = 0; i < D; i++) begin : g_slot
            assign keep_here[i] = (CW'(i) < cnt_i) && (llr_i[i] <= new_llr);

            if (i == 0) begin : g_head
                always_comb begin
                    if (!new_vld || keep_here[0]) begin
                        llr_o[0] = llr_i[0];
                        idx_o[0] = idx_i[0];
                    end else begin
                        llr_o[0] = new_llr;
                        idx_o[0] = new_idx;
                    end
                end
            end else begin : g_body
                always_comb begin
                    if (!new_vld || keep_here[i]) begin
                        llr_o[i] = llr_i[i];
                        idx_o[i] = idx_i[i];
                    end else if (keep_here[i-1]) begin
                        llr_o[i] = new_llr;
                        idx_o[i] = new_idx;
                    end else begin
                        llr_o[i] = llr_i[i-1];
                        idx_o[i] = idx_i[i-1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        cnt_o = cnt_i;
        if (new_vld && !keep_here[D-1] && (cnt_i != CW'(D))) begin
            cnt_o = cnt_i + CW'(1);
        end
    end

endmodule

// File: rtl/llr_sort_list.sv
module llr_sort_list #(
    parameter int D     = 7,
    parameter int QW    = 6,
    parameter int IW    = 7,
    parameter int CW    = 3,
    parameter int LANES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wipe,
    input  logic                     accept,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES-1:0][QW-1:0] lane_llr,
    input  logic [LANES-1:0][IW-1:0] lane_idx,
    output logic [D-1:0][QW-1:0]     list_llr,
    output logic [D-1:0][IW-1:0]     list_idx,
    output logic [CW-1:0]            list_cnt
);

    logic [D-1:0][QW-1:0] llr_q;
    logic [D-1:0][IW-1:0] idx_q;
    logic [CW-1:0]        cnt_q;

    logic [D-1:0][QW-1:0] chain_llr [LANES+1];
    logic [D-1:0][IW-1:0] chain_idx [LANES+1];
    logic [CW-1:0]        chain_cnt [LANES+1];

    assign chain_llr[0] = llr_q;
    assign chain_idx[0] = idx_q;
    assign chain_cnt[0] = cnt_q;

    // One stage per lane: lane 0 is inserted first, so it ranks ahead on ties.
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            llr_insert_stage #(
                .D (D),
                .QW(QW),
                .IW(IW),
                .CW(CW)
            ) u_stage (
                .llr_i  (chain_llr[j]),
                .idx_i  (chain_idx[j]),
                .cnt_i  (chain_cnt[j]),
                .new_vld(lane_vld[j]),
                .new_llr(lane_llr[j]),
                .new_idx(lane_idx[j]),
                .llr_o  (chain_llr[j+1]),
                .idx_o  (chain_idx[j+1]),
                .cnt_o  (chain_cnt[j+1])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            llr_q <= '0;
            idx_q <= '0;
            cnt_q <= '0;
        end else if (wipe) begin
            llr_q <= '0;
            idx_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            llr_q <= chain_llr[LANES];
            idx_q <= chain_idx[LANES];
            cnt_q <= chain_cnt[LANES];
        end
    end

    assign list_llr = llr_q;
    assign list_idx = idx_q;
    assign list_cnt = cnt_q;

endmodule

// File: rtl/llr_flip_sorter.sv
module llr_flip_sorter #(
    parameter int TMAX  = 8,
    parameter int QW    = 6,
    parameter int KBITS = 128,
    parameter int P     = 4,
    localparam int D     = TMAX - 1,
    localparam int IW    = $clog2(KBITS),
    localparam int CW    = $clog2(D + 1),
    localparam int LANES = sorter_pkg::lanes_for(P, TMAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [LANES-1:0]    ins_vld,
    input  logic [LANES*QW-1:0] ins_llr,
    input  logic [LANES*IW-1:0] ins_idx,
    input  logic                done,
    input  logic                req,
    output logic [CW-1:0]       fill_cnt,
    output logic                rsp_hit,
    output logic                rsp_exh,
    output logic [IW-1:0]       rsp_idx
);
    import sorter_pkg::*;

    localparam int SW = (D > 1) ? $clog2(D) : 1;

    flip_state_e st_q;
    flip_state_e st_d;

    logic                     collecting;
    logic [LANES-1:0][QW-1:0] lane_llr;
    logic [LANES-1:0][IW-1:0] lane_idx;
    logic [D-1:0][QW-1:0]     list_llr;
    logic [D-1:0][IW-1:0]     list_idx;
    logic [CW-1:0]            list_cnt;
    logic [CW-1:0]            rank_q;
    logic                     have_entry;

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_unpack
            assign lane_llr[j] = ins_llr[j*QW +: QW];
            assign lane_idx[j] = ins_idx[j*IW +: IW];
        end
    endgenerate

    assign collecting = (st_q == ST_COLLECT);
    assign have_entry = (rank_q < list_cnt);

    llr_sort_list #(
        .D    (D),
        .QW   (QW),
        .IW   (IW),
        .CW   (CW),
        .LANES(LANES)
    ) u_list (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (clr),
        .accept  (collecting),
        .lane_vld(ins_vld),
        .lane_llr(lane_llr),
        .lane_idx(lane_idx),
        .list_llr(list_llr),
        .list_idx(list_idx),
        .list_cnt(list_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_COLLECT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = ST_COLLECT;                         // CLEAR
        end else begin
            unique case (st_q)
                ST_COLLECT: if (done) st_d = ST_SERVE; // CLOSE
                ST_SERVE: begin
                    if (req) begin
                        if (!have_entry) begin
                            st_d = ST_SPENT;           // EMPTY_REQ
                        end else if (rank_q + CW'(1) >= list_cnt) begin
                            st_d = ST_SPENT;           // LAST_HIT
                        end
                    end
                end
                ST_SPENT:   st_d = ST_SPENT;
                default:    st_d = ST_COLLECT;
            endcase
        end
    end

    // Output and rank register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit <= 1'b0;
            rsp_exh <= 1'b0;
            rsp_idx <= '0;
            rank_q  <= '0;
        end else begin
            rsp_hit <= 1'b0;
            rsp_exh <= 1'b0;
            if (clr) begin
                rank_q <= '0;
            end else begin
                unique case (st_q)
                    ST_COLLECT: rank_q <= '0;
                    ST_SERVE: begin
                        if (req) begin
                            if (have_entry) begin
                                rsp_hit <= 1'b1;
                                rsp_idx <= list_idx[rank_q[SW-1:0]];
                                rank_q  <= rank_q + CW'(1);
                            end else begin
                                rsp_exh <= 1'b1;
                            end
                        end
                    end
                    ST_SPENT:   if (req) rsp_exh <= 1'b1;
                    default:    rank_q <= '0;
                endcase
            end
        end
    end

    assign fill_cnt = list_cnt;

endmodule

// File: rtl/llr_sorter_chk.sv
module llr_sorter_chk #(
    parameter int D     = 7,
    parameter int QW    = 6,
    parameter int CW    = 3,
    parameter int LANES = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic                 req,
    input logic                 collecting,
    input logic [CW-1:0]        fill_cnt,
    input logic                 rsp_hit,
    input logic                 rsp_exh,
    input logic [D-1:0][QW-1:0] list_llr
);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_cnt) <= D);

    assert_lane_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> int'(fill_cnt) <= int'($past(fill_cnt)) + LANES);

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill_cnt == '0) && !rsp_hit && !rsp_exh);

    assert_frozen_after_collect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!collecting && !clr) |=> $stable(fill_cnt));

    assert_rsp_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_exh) |-> ($past(req) && !$past(clr)));

    assert_rsp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_exh}));

    assert_no_rsp_collect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && req) |=> (!rsp_hit && !rsp_exh));

    generate
        for (genvar i = 0; i < D - 1; i++) begin : g_order
            assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (CW'(i + 1) < fill_cnt) |-> (list_llr[i] <= list_llr[i+1]));
        end
    endgenerate

endmodule

bind llr_flip_sorter llr_sorter_chk #(
    .D    (D),
    .QW   (QW),
    .CW   (CW),
    .LANES(LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .req       (req),
    .collecting(collecting),
    .fill_cnt  (fill_cnt),
    .rsp_hit   (rsp_hit),
    .rsp_exh   (rsp_exh),
    .list_llr  (list_llr)
);

// File: tb/sim_llr_flip_sorter.sv
`timescale 1ns/1ps
module sim_llr_flip_sorter;

    localparam int TMAX  = 8;
    localparam int QW    = 6;
    localparam int KBITS = 128;
    localparam int P     = 4;
    localparam int D     = TMAX - 1;
    localparam int IW    = $clog2(KBITS);
    localparam int CW    = $clog2(D + 1);
    localparam int LANES = ((P - 1) < (TMAX - 1)) ? (P - 1) : (TMAX - 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                clr = 1'b0;
    logic [LANES-1:0]    ins_vld = '0;
    logic [LANES*QW-1:0] ins_llr = '0;
    logic [LANES*IW-1:0] ins_idx = '0;
    logic                done = 1'b0;
    logic                req = 1'b0;
    logic [CW-1:0]       fill_cnt;
    logic                rsp_hit;
    logic                rsp_exh;
    logic [IW-1:0]       rsp_idx;

    int n_checks = 0;
    int n_fail   = 0;

    // reference list
    int m_llr [D];
    int m_idx [D];
    int m_cnt = 0;

    always #10 clk = ~clk;   // 50 MHz

    llr_flip_sorter #(.TMAX(TMAX), .QW(QW), .KBITS(KBITS), .P(P)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ins_vld(ins_vld),
        .ins_llr(ins_llr), .ins_idx(ins_idx), .done(done), .req(req),
        .fill_cnt(fill_cnt), .rsp_hit(rsp_hit), .rsp_exh(rsp_exh), .rsp_idx(rsp_idx)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_insert(input int v, input int ix);
        int pos = m_cnt;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_llr[i] > v) begin
                pos = i;
                break;
            end
        end
        if (pos < D) begin
            for (int i = D - 1; i > pos; i--) begin
                m_llr[i] = m_llr[i-1];
                m_idx[i] = m_idx[i-1];
            end
            m_llr[pos] = v;
            m_idx[pos] = ix;
            if (m_cnt < D) m_cnt++;
        end
    endfunction

    task automatic do_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        m_cnt = 0;
        chk(fill_cnt == 0, "R6 clear count", int'(fill_cnt), 0);
    endtask

    // n lanes valid; model updated only when 'into_model' is set
    task automatic push(input int n, input bit into_model,
                        input int l0, input int x0, input int l1, input int x1,
                        input int l2, input int x2);
        int ll [3];
        int xx [3];
        ll = '{l0, l1, l2};
        xx = '{x0, x1, x2};
        for (int j = 0; j < LANES; j++) begin
            ins_vld[j] = (j < n);
            ins_llr[j*QW +: QW] = QW'(ll[j]);
            ins_idx[j*IW +: IW] = IW'(xx[j]);
            if (into_model && j < n) model_insert(ll[j], xx[j]);
        end
        tick();
        ins_vld = '0;
    endtask

    task automatic close_trial();
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    task automatic serve_all(input string tag);
        chk(int'(fill_cnt) == m_cnt, {tag, " count"}, int'(fill_cnt), m_cnt);
        for (int r = 0; r <= m_cnt; r++) begin
            req = 1'b1;
            tick();
            req = 1'b0;
            if (r < m_cnt) begin
                chk(rsp_hit && !rsp_exh, {tag, " R8 hit"}, int'(rsp_hit), 1);
                chk(int'(rsp_idx) == m_idx[r], {tag, " R2 rank idx"}, int'(rsp_idx), m_idx[r]);
            end else begin
                chk(rsp_exh && !rsp_hit, {tag, " R9 exhausted"}, int'(rsp_exh), 1);
            end
        end
    endtask

    task automatic t_reset();
        chk(fill_cnt == 0, "R1 count", int'(fill_cnt), 0);
        chk(!rsp_hit && !rsp_exh, "R1 no response", int'({rsp_hit, rsp_exh}), 0);
    endtask

    task automatic t_basic();   // R2 R4 R8 R9
        do_clear();
        push(3, 1'b1, 20, 5, 3, 9, 11, 1);
        chk(fill_cnt == 3, "R4 three lanes in one cycle", int'(fill_cnt), 3);
        push(1, 1'b1, 7, 40, 0, 0, 0, 0);
        close_trial();
        serve_all("basic");
    endtask

    task automatic t_overflow();   // R3
        do_clear();
        push(3, 1'b1, 30, 10, 25, 11, 40, 12);
        push(3, 1'b1, 2, 13, 50, 14, 17, 15);
        push(3, 1'b1, 9, 16, 33, 17, 1, 18);
        push(3, 1'b1, 60, 19, 12, 20, 5, 21);
        chk(fill_cnt == D, "R3 capped count", int'(fill_cnt), D);
        push(1, 1'b1, 63, 22, 0, 0, 0, 0);   // not smaller than any: dropped
        chk(fill_cnt == D, "R3 drop when full", int'(fill_cnt), D);
        chk(m_llr[D-1] == 25, "R3 model largest kept", m_llr[D-1], 25);
        close_trial();
        serve_all("R3 overflow");
    endtask

    task automatic t_ties();   // R5
        do_clear();
        push(3, 1'b1, 10, 1, 10, 2, 4, 3);
        push(2, 1'b1, 10, 4, 4, 5, 0, 0);
        close_trial();
        serve_all("R5 ties");
    endtask

    task automatic t_late_insert();   // R7
        do_clear();
        push(1, 1'b1, 8, 70, 0, 0, 0, 0);
        done = 1'b1;                         // insert in the closing cycle counts
        push(1, 1'b1, 6, 72, 0, 0, 0, 0);
        done = 1'b0;
        push(2, 1'b0, 1, 71, 0, 73, 0, 0);   // after close: ignored
        chk(fill_cnt == 2, "R7 count frozen", int'(fill_cnt), 2);
        serve_all("R7 late");
    endtask

    task automatic t_req_collect();   // R10
        do_clear();
        push(2, 1'b1, 15, 30, 12, 31, 0, 0);
        req = 1'b1;
        tick();
        req = 1'b0;
        chk(!rsp_hit && !rsp_exh, "R10 no response in collect", int'({rsp_hit, rsp_exh}), 0);
        close_trial();
        serve_all("R10 rank kept");
    endtask

    task automatic t_clear_override();   // R6, R9 empty
        do_clear();
        push(2, 1'b1, 3, 50, 4, 51, 0, 0);
        clr = 1'b1;
        done = 1'b1;
        push(2, 1'b0, 1, 52, 2, 53, 0, 0);   // same cycle as clr: dropped
        clr = 1'b0;
        done = 1'b0;
        m_cnt = 0;
        chk(fill_cnt == 0, "R6 clear overrides insert", int'(fill_cnt), 0);
        close_trial();
        serve_all("R9 empty list");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_overflow();
        t_ties();
        t_late_insert();
        t_req_collect();
        t_clear_override();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule